// File: doc/BRIEF.md
# Clear-on-Read Ethernet Statistics Counter Bank

This block keeps a set of event counters for an Ethernet MAC. Eleven one-cycle strobes arrive from the MAC, each for one kind of event: CRC errors, receive errors, single and excessive collisions, good frames received, broadcast and multicast frames received, total frames received and transmitted, and multicast and broadcast frames transmitted. Each strobe adds one to its own counter. Software sees the counters through a simple request port and cannot write them. A read is destructive: it returns the count and zeroes that counter in the same step.

The counters sit at fixed, sparse byte offsets inside a 4 KB window that starts at 0x4000. Only the eleven aligned offsets listed below are mapped. Any other address reads as zero. The response comes back registered, one cycle after the request. A request is taken in the cycle its valid bit is high. There is no ready signal and no back-pressure. The requester must take the response in the cycle `rsp_valid` is high, because the block neither holds nor repeats it.

Top module: `stat_counter_bank`

## Requirements
- R1: Each cycle that an event strobe is high, its counter grows by one. The strobe-to-offset map is: bit 0 CRC error at 0x4000, bit 1 receive error at 0x400C, bit 2 single collision at 0x4014, bit 3 excessive collision at 0x4018, bit 4 good received at 0x4074, bit 5 broadcast received at 0x4078, bit 6 multicast received at 0x407C, bit 7 total received at 0x40D0, bit 8 total transmitted at 0x40D4, bit 9 multicast transmitted at 0x40F0, bit 10 broadcast transmitted at 0x40F4.
- R2: A read is a cycle with `req_valid`=1 and `req_we`=0. The cycle after a read, `rsp_valid` is 1 and `rsp_data` holds the count as it was at the read. In any cycle that does not follow a read, `rsp_valid` is 0.
- R3: A read of a mapped offset leaves that counter at zero. Other counters are not affected.
- R4: If a read and that counter's event strobe fall in the same cycle, the read returns the old count and the counter becomes 1.
- R5: A counter that has reached all ones stays at all ones when further events arrive. It does not wrap.
- R6: A read of any unmapped address returns zero and changes no counter. This covers misaligned addresses, unmapped words in the window, and addresses outside the window.
- R7: A write (`req_valid`=1, `req_we`=1) changes no counter and produces no response.
- R8: Reading every aligned word from 0x4000 to 0x4FFC in turn leaves every counter at zero.
- R9: After reset, every counter is zero and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_CNT | One-cycle event strobes; the bit order is given in R1 |
| req_valid | input | 1 | Request taken in this cycle |
| req_we | input | 1 | 1 = write (ignored), 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| rsp_valid | output | 1 | Read data valid; high the cycle after a read |
| rsp_data | output | CNT_W | Count returned by the read |

## Verification
The bench builds the bank with CNT_W set to 8 and all other parameters at their defaults. An 8-bit counter reaches all ones after 255 strobes. This lets the bench drive a counter into saturation in a few hundred cycles and show that the count holds at all ones (0xFF). The address map and the window are the same as with 32-bit counters. The full sweep of 1024 words and all the unmapped-address cases therefore run against the real map.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int NUM_EVT  = 11;
  localparam int OFF_W    = 16;
  localparam logic [OFF_W-1:0] WIN_BASE = 16'h4000;

  typedef enum int {
    EV_CRC_ERR  = 0,
    EV_RX_ERR   = 1,
    EV_SGL_COL  = 2,
    EV_EXC_COL  = 3,
    EV_GOOD_RX  = 4,
    EV_BC_RX    = 5,
    EV_MC_RX    = 6,
    EV_TOT_RX   = 7,
    EV_TOT_TX   = 8,
    EV_MC_TX    = 9,
    EV_BC_TX    = 10
  } evt_idx_e;

  // byte offset of the counter fed by event index i
  function automatic logic [OFF_W-1:0] cnt_offset(input int i);
    case (i)
      EV_CRC_ERR: cnt_offset = 16'h4000;
      EV_RX_ERR:  cnt_offset = 16'h400C;
      EV_SGL_COL: cnt_offset = 16'h4014;
      EV_EXC_COL: cnt_offset = 16'h4018;
      EV_GOOD_RX: cnt_offset = 16'h4074;
      EV_BC_RX:   cnt_offset = 16'h4078;
      EV_MC_RX:   cnt_offset = 16'h407C;
      EV_TOT_RX:  cnt_offset = 16'h40D0;
      EV_TOT_TX:  cnt_offset = 16'h40D4;
      EV_MC_TX:   cnt_offset = 16'h40F0;
      EV_BC_TX:   cnt_offset = 16'h40F4;
      default:    cnt_offset = 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/stat_addr_decode.sv
module stat_addr_decode #(
  parameter int ADDR_W  = 16,
  parameter int NUM_CNT = stat_pkg::NUM_EVT
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_CNT-1:0] sel,
  output logic               hit
);
  import stat_pkg::*;

  // parallel comparators, one per mapped offset; misaligned never matches
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cmp
    localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(cnt_offset(i));
    assign sel[i] = (addr == OFFS);
  end

  assign hit = |sel;
endmodule

// File: rtl/stat_counter.sv
module stat_counter #(
  parameter int CNT_W    = 32,
  parameter bit SATURATE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] MAX_VAL = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] bumped;

  if (SATURATE) begin : g_sat
    assign bumped = (cnt == MAX_VAL) ? MAX_VAL : cnt + ONE;
  end else begin : g_wrap
    assign bumped = cnt + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      // event seen during the clearing read is kept
      cnt <= inc ? ONE : '0;
    end else if (inc) begin
      cnt <= bumped;
    end
  end
endmodule

// File: rtl/stat_read_mux.sv
module stat_read_mux #(
  parameter int CNT_W   = 32,
  parameter int NUM_CNT = stat_pkg::NUM_EVT
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rd,
  input  logic [NUM_CNT-1:0]              sel,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt,
  output logic                            rsp_valid,
  output logic [CNT_W-1:0]                rsp_data
);
  logic [CNT_W-1:0] picked;

  // AND-OR select; all-zero sel gives zero
  always_comb begin
    picked = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      picked = picked | (cnt[i] & {CNT_W{sel[i]}});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_data <= picked;
    end
  end
endmodule

// File: rtl/stat_counter_bank.sv
module stat_counter_bank #(
  parameter int CNT_W    = 32,
  parameter int ADDR_W   = 16,
  parameter int NUM_CNT  = stat_pkg::NUM_EVT,
  parameter bit SATURATE = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CNT-1:0] evt_i,
  input  logic               req_valid,
  input  logic               req_we,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               rsp_valid,
  output logic [CNT_W-1:0]   rsp_data
);
  logic                          rd;
  logic                          hit;
  logic [NUM_CNT-1:0]            sel;
  logic [NUM_CNT-1:0]            clr_vec;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;

  assign rd      = req_valid & ~req_we;
  assign clr_vec = sel & {NUM_CNT{rd}};

  stat_addr_decode #(.ADDR_W(ADDR_W), .NUM_CNT(NUM_CNT)) u_dec (
    .addr (req_addr),
    .sel  (sel),
    .hit  (hit)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    stat_counter #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (evt_i[i]),
      .clr   (clr_vec[i]),
      .cnt   (cnt_q[i])
    );
  end

  stat_read_mux #(.CNT_W(CNT_W), .NUM_CNT(NUM_CNT)) u_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd        (rd),
    .sel       (sel),
    .cnt       (cnt_q),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );
endmodule

// File: rtl/stat_counter_bank_chk.sv
module stat_counter_bank_chk #(
  parameter int CNT_W    = 32,
  parameter int NUM_CNT  = 11,
  parameter bit SATURATE = 1'b1
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          req_valid,
  input logic                          req_we,
  input logic                          hit,
  input logic [NUM_CNT-1:0]            evt_i,
  input logic [NUM_CNT-1:0]            clr_vec,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q,
  input logic                          rsp_valid,
  input logic [CNT_W-1:0]              rsp_data
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  assert_rsp_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we) |=> rsp_valid);
  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_we) |=> !rsp_valid);
  assert_unmapped_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we && !hit) |=> (rsp_data == '0));

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_c
    assert_inc_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i[i] && !clr_vec[i] && cnt_q[i] != MAXV) |=> cnt_q[i] == $past(cnt_q[i]) + 1'b1);
    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[i] && !evt_i[i]) |=> cnt_q[i] == '0);
    assert_clear_evt_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[i] && evt_i[i]) |=> cnt_q[i] == CNT_W'(1));
    assert_write_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_we && !evt_i[i]) |=> $stable(cnt_q[i]));
    if (SATURATE) begin : g_s
      assert_sat_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q[i] == MAXV && !clr_vec[i]) |=> cnt_q[i] == MAXV);
    end
  end
endmodule

bind stat_counter_bank stat_counter_bank_chk #(
  .CNT_W(CNT_W), .NUM_CNT(NUM_CNT), .SATURATE(SATURATE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_we    (req_we),
  .hit       (hit),
  .evt_i     (evt_i),
  .clr_vec   (clr_vec),
  .cnt_q     (cnt_q),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data)
);

// File: tb/stat_counter_bank_tb.sv
module stat_counter_bank_tb;
  localparam int W = 8;
  localparam int N = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  evt_i = '0;
  logic          req_valid = 1'b0;
  logic          req_we = 1'b0;
  logic [15:0]   req_addr = '0;
  logic          rsp_valid;
  logic [W-1:0]  rsp_data;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  stat_counter_bank #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .req_valid(req_valid),
    .req_we(req_we), .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [N-1:0] mask, input int n);
    if (n > 0) begin
      @(negedge clk); evt_i = mask;
      repeat (n) @(negedge clk);
      evt_i = '0;
    end
  endtask

  // read; sample response at the next falling edge
  task automatic rd(input logic [15:0] a, output logic v, output logic [W-1:0] d);
    @(negedge clk); req_valid = 1'b1; req_we = 1'b0; req_addr = a;
    @(negedge clk); req_valid = 1'b0;
    v = rsp_valid; d = rsp_data;
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a, input logic [W-1:0] exp);
    logic v; logic [W-1:0] d;
    rd(a, v, d);
    check({req, " valid"}, 32'(v), 32'd1);
    check(req, 32'(d), 32'(exp));
  endtask

  // {event mask, pulse cycles, read address, expected count}
  localparam int NV = 20;
  localparam logic [42:0] VEC [NV] = '{
    {11'h001, 8'd3, 16'h4000, 8'd3},   // R1 R2
    {11'h000, 8'd0, 16'h4000, 8'd0},   // R3
    {11'h006, 8'd5, 16'h400C, 8'd5},
    {11'h000, 8'd0, 16'h4014, 8'd5},
    {11'h000, 8'd0, 16'h4014, 8'd0},
    {11'h180, 8'd2, 16'h40D0, 8'd2},
    {11'h000, 8'd0, 16'h40D4, 8'd2},
    {11'h7FF, 8'd1, 16'h4018, 8'd1},
    {11'h000, 8'd0, 16'h4074, 8'd1},
    {11'h000, 8'd0, 16'h4078, 8'd1},
    {11'h000, 8'd0, 16'h407C, 8'd1},
    {11'h000, 8'd0, 16'h40D0, 8'd1},
    {11'h000, 8'd0, 16'h40D4, 8'd1},
    {11'h000, 8'd0, 16'h40F0, 8'd1},
    {11'h000, 8'd0, 16'h40F4, 8'd1},
    {11'h000, 8'd0, 16'h4000, 8'd1},
    {11'h000, 8'd0, 16'h400C, 8'd1},
    {11'h000, 8'd0, 16'h4014, 8'd1},
    {11'h000, 8'd0, 16'h4004, 8'd0},   // R6
    {11'h000, 8'd0, 16'h4FFC, 8'd0}
  };

  localparam logic [15:0] MAPPED [N] = '{16'h4000, 16'h400C, 16'h4014, 16'h4018,
    16'h4074, 16'h4078, 16'h407C, 16'h40D0, 16'h40D4, 16'h40F0, 16'h40F4};

  initial begin
    logic v; logic [W-1:0] d;
    repeat (3) @(negedge clk);
    check("R9 rsp_valid in reset", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    for (int i = 0; i < N; i++) rd_chk("R9 counter zero", MAPPED[i], '0);

    for (int k = 0; k < NV; k++) begin
      pulse(VEC[k][42:32], int'(VEC[k][31:24]));
      rd_chk("R1/R2/R3 vector", VEC[k][23:8], VEC[k][7:0]);
    end

    // R5 saturation
    pulse(11'h010, 300);
    rd_chk("R5 saturate", 16'h4074, 8'hFF);
    rd_chk("R3 cleared after saturate", 16'h4074, 8'h00);

    // R4 event during clearing read
    pulse(11'h020, 4);
    @(negedge clk); evt_i = 11'h020; req_valid = 1'b1; req_we = 1'b0; req_addr = 16'h4078;
    @(negedge clk); evt_i = '0; req_valid = 1'b0;
    check("R4 old value", 32'(rsp_data), 32'd4);
    rd_chk("R4 counter is one", 16'h4078, 8'd1);

    // R7 write ignored, no response
    pulse(11'h200, 3);
    @(negedge clk); req_valid = 1'b1; req_we = 1'b1; req_addr = 16'h40F0;
    @(negedge clk); req_valid = 1'b0; req_we = 1'b0;
    check("R7 no response to write", 32'(rsp_valid), 32'd0);
    rd_chk("R7 count kept", 16'h40F0, 8'd3);

    // R6 unmapped reads: no side effect
    pulse(11'h401, 2);
    rd_chk("R6 unmapped in window", 16'h40F8, 8'd0);
    rd_chk("R6 misaligned", 16'h4001, 8'd0);
    rd_chk("R6 outside window", 16'h3000, 8'd0);
    rd_chk("R6 count kept", 16'h40F4, 8'd2);
    rd_chk("R6 count kept", 16'h4000, 8'd2);

    // R8 sweep clears everything
    pulse(11'h7FF, 2);
    for (int a = 'h4000; a < 'h5000; a += 4) rd(16'(a), v, d);
    for (int i = 0; i < N; i++) rd_chk("R8 zero after sweep", MAPPED[i], '0);

    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule